// File: doc/BRIEF.md
# Privileged Special-Register Access Unit

This block is the small register file that a microcontroller-class core reaches through its move-to-special-register and move-from-special-register instructions. A 5-bit register number picks the target, a privilege flag says whether the access comes from privileged code, and separate read and write strobes carry the access. Read data is combinational from the register number and the stored state. A write lands on the rising clock edge while the write strobe is high.

The unit holds five condition flags, two stack pointers, the priority-mask registers and a two-bit control register. The stack pointers are kept as an active copy and a banked copy. The active exception number comes in from the exception logic and is only shown through the status views. Numbers 0 to 7 are composite views of the program status word. Each view is built from bits of the number: bit 0 set adds the exception number, and bit 2 clear adds the flags. Unprivileged code is restricted without any fault, and a privileged access to a number that has no register raises an error pulse.

There is no sequencing inside the block. The only stateful behaviour is the write decode and the exchange of the stack-pointer pair when the stack-select bit changes.

Top module: `sreg_access_unit`

## Requirements
- R1: After reset, all stored state is zero, so every register number reads zero at either privilege level.
- R2: For numbers 0 to 7, a privileged read returns the flags in bits 31:27 when bit 2 of the number is clear, and exc_num in bits 8:0 when bit 0 of the number is set. All other bits read zero.
- R3: For numbers 0 to 7, an unprivileged read shows bits 8:0 as zero and still shows the flags exactly as in R2.
- R4: A write to any number 0 to 7, at either privilege level, loads the flags from wdata[31:27] and changes no other state.
- R5: Number 8 is the main stack pointer and number 9 is the process stack pointer. Each is written and read in full 32 bits. The value seen under each number is independent of control bit 1.
- R6: A write to number 20 keeps only wdata[1:0], where bit 0 is the unprivileged-thread flag and bit 1 is the stack select. When bit 1 changes, the active and banked stack pointers are exchanged, so R5 still holds.
- R7: Number 16 (primask) and number 19 (faultmask) store and read back wdata[0] only. Number 17 (basepri) stores and reads back wdata[7:0]. Their upper bits read zero.
- R8: An unprivileged read of any number above 7 other than 20 returns zero. Number 20 reads the control register at either privilege level.
- R9: An unprivileged write to any number above 7 changes no state.
- R10: The unimplemented numbers (10 to 15, 18 and 21 to 31) read zero and ignore writes. unk_err is high in the same cycle as a privileged read or write strobe to one of them, and low otherwise.
- R11: Read data follows the register number with no clock delay. A write becomes visible only after the rising edge it is sampled on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 5 | Special-register number |
| priv | input | 1 | 1 = privileged access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write value |
| exc_num | input | 9 | Active exception number from the exception logic |
| rdata | output | 32 | Read data |
| unk_err | output | 1 | Unknown-register error pulse |

## Verification
The bench builds the unit with its default widths: 32-bit data, a 9-bit exception field, five flags and an 8-bit base priority. With these widths the whole 32-entry register space, crossed with both privilege levels, can be swept after every write stage. Each sweep compares every number against a named-register model, so all-ones write patterns expose any stray bit above a field's width. The stack-pointer exchange is checked by writing through both numbers under both stack-select settings; a missing or doubled exchange shows up as a pointer value under the wrong number.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int NUM_W = 5;

    // Control register bit positions
    localparam int CTRL_UNPRIV = 0;
    localparam int CTRL_SPSEL  = 1;

    typedef enum logic [2:0] {
        K_STATUS,
        K_MSP,
        K_PSP,
        K_PRIMASK,
        K_BASEPRI,
        K_FAULTMASK,
        K_CONTROL,
        K_UNKNOWN
    } sreg_kind_e;
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
    import sreg_pkg::*;
(
    input  logic [NUM_W-1:0] sel,
    output sreg_kind_e       kind
);
    always_comb begin
        unique case (sel)
            5'd0, 5'd1, 5'd2, 5'd3,
            5'd4, 5'd5, 5'd6, 5'd7: kind = K_STATUS;
            5'd8:                   kind = K_MSP;
            5'd9:                   kind = K_PSP;
            5'd16:                  kind = K_PRIMASK;
            5'd17:                  kind = K_BASEPRI;
            5'd19:                  kind = K_FAULTMASK;
            5'd20:                  kind = K_CONTROL;
            default:                kind = K_UNKNOWN;
        endcase
    end
endmodule

// File: rtl/sreg_stack_bank.sv
module sreg_stack_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_main,
    input  logic         wr_proc,
    input  logic [W-1:0] wdata,
    input  logic         use_proc,
    input  logic         swap,
    output logic [W-1:0] main_sp,
    output logic [W-1:0] proc_sp
);
    logic [W-1:0] act_q, bank_q;

    assign main_sp = use_proc ? bank_q : act_q;
    assign proc_sp = use_proc ? act_q  : bank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            bank_q <= '0;
        end else if (swap) begin
            act_q  <= bank_q;
            bank_q <= act_q;
        end else if (wr_main) begin
            if (use_proc) bank_q <= wdata;
            else          act_q  <= wdata;
        end else if (wr_proc) begin
            if (use_proc) act_q  <= wdata;
            else          bank_q <= wdata;
        end
    end

    // R6: a stack-select change exchanges the pair exactly
    p_swap_exchange_r6: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (act_q == $past(bank_q)) && (bank_q == $past(act_q)));
endmodule

// File: rtl/sreg_access_unit.sv
module sreg_access_unit
    import sreg_pkg::*;
#(
    parameter int W      = 32,
    parameter int EXC_W  = 9,
    parameter int FLAG_W = 5,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_W-1:0]  sel,
    input  logic              priv,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [W-1:0]      wdata,
    input  logic [EXC_W-1:0]  exc_num,
    output logic [W-1:0]      rdata,
    output logic              unk_err
);
    localparam int FLAG_LSB = W - FLAG_W;

    sreg_kind_e        kind;
    logic [FLAG_W-1:0] flags_q;
    logic              primask_q;
    logic              fault_q;
    logic [PRIO_W-1:0] basepri_q;
    logic [1:0]        ctrl_q;
    logic [W-1:0]      msp_v, psp_v;
    logic              wr_gate;
    logic              sp_swap;

    sreg_decode u_dec (
        .sel  (sel),
        .kind (kind)
    );

    // Status views accept writes at any privilege; the rest need priv
    assign wr_gate = wr_en && (priv || (kind == K_STATUS));
    assign sp_swap = wr_gate && (kind == K_CONTROL) &&
                     (wdata[CTRL_SPSEL] != ctrl_q[CTRL_SPSEL]);

    sreg_stack_bank #(.W(W)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_main  (wr_gate && (kind == K_MSP)),
        .wr_proc  (wr_gate && (kind == K_PSP)),
        .wdata    (wdata),
        .use_proc (ctrl_q[CTRL_SPSEL]),
        .swap     (sp_swap),
        .main_sp  (msp_v),
        .proc_sp  (psp_v)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q   <= '0;
            primask_q <= 1'b0;
            fault_q   <= 1'b0;
            basepri_q <= '0;
            ctrl_q    <= '0;
        end else if (wr_gate) begin
            unique case (kind)
                K_STATUS:    flags_q   <= wdata[W-1 -: FLAG_W];
                K_PRIMASK:   primask_q <= wdata[0];
                K_BASEPRI:   basepri_q <= wdata[PRIO_W-1:0];
                K_FAULTMASK: fault_q   <= wdata[0];
                K_CONTROL:   ctrl_q    <= wdata[1:0];
                default:     ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (kind)
            K_STATUS: begin
                if (!sel[2])         rdata[W-1 -: FLAG_W] = flags_q;
                if (sel[0] && priv)  rdata[EXC_W-1:0]     = exc_num;
            end
            K_CONTROL:   rdata[1:0] = ctrl_q;
            K_MSP:       if (priv) rdata = msp_v;
            K_PSP:       if (priv) rdata = psp_v;
            K_PRIMASK:   if (priv) rdata[0] = primask_q;
            K_BASEPRI:   if (priv) rdata[PRIO_W-1:0] = basepri_q;
            K_FAULTMASK: if (priv) rdata[0] = fault_q;
            default:     rdata = '0;
        endcase
    end

    assign unk_err = priv && (rd_en || wr_en) && (kind == K_UNKNOWN);

    // R3: exception field hidden from unprivileged status reads
    p_exc_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv && sel < 5'd8) |-> (rdata[EXC_W-1:0] == '0));

    // R4: flags move only on a status-view write
    p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel < 5'd8) |=> $stable(flags_q));

    // R8: unprivileged reads above 7 return zero except control
    p_unpriv_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv && sel >= 5'd8 && sel != 5'd20) |-> (rdata == '0));

    // R9: unprivileged writes above 7 leave state alone
    p_unpriv_wr_ign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv && wr_en && sel >= 5'd8) |=> ($stable(ctrl_q) && $stable(primask_q)
            && $stable(basepri_q) && $stable(fault_q) && $stable(msp_v) && $stable(psp_v)));

    // R10: an error pulse always comes with zero read data
    p_unknown_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unk_err |-> (rdata == '0));
endmodule

// File: tb/sreg_access_unit_test.sv
module sreg_access_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  sel = '0;
    logic        priv = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [8:0]  exc_num = '0;
    logic [31:0] rdata;
    logic        unk_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Named-register model
    logic [4:0]  m_flags = '0;
    logic [31:0] m_msp = '0, m_psp = '0;
    logic [1:0]  m_ctrl = '0;
    logic        m_pm = 1'b0, m_fm = 1'b0;
    logic [7:0]  m_bp = '0;

    always #5 clk = ~clk;

    sreg_access_unit uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .priv(priv), .rd_en(rd_en),
        .wr_en(wr_en), .wdata(wdata), .exc_num(exc_num),
        .rdata(rdata), .unk_err(unk_err)
    );

    function automatic bit is_unk(input logic [4:0] s);
        return !(s < 5'd10 || s == 5'd16 || s == 5'd17 || s == 5'd19 || s == 5'd20);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [4:0] s, input bit p);
        logic [31:0] r = '0;
        if (s < 5'd8) begin
            if (!s[2])      r[31:27] = m_flags;
            if (s[0] && p)  r[8:0]   = exc_num;
            return r;
        end
        if (s == 5'd20) return {30'b0, m_ctrl};
        if (!p) return '0;
        case (s)
            5'd8:    r = m_msp;
            5'd9:    r = m_psp;
            5'd16:   r = {31'b0, m_pm};
            5'd17:   r = {24'b0, m_bp};
            5'd19:   r = {31'b0, m_fm};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input logic [4:0] s, input bit p, input string tag);
        @(negedge clk);
        sel = s; priv = p; rd_en = 1'b1;
        #1;
        tests++;
        if (rdata !== exp_rd(s, p)) begin
            fails++;
            $display("FAIL %s read sel=%0d priv=%0d actual=%h expected=%h", tag, s, p, rdata, exp_rd(s, p));
        end
        tests++;
        if (unk_err !== (p && is_unk(s))) begin
            fails++;
            $display("FAIL R10 (%s) err sel=%0d priv=%0d actual=%b expected=%b", tag, s, p, unk_err, p && is_unk(s));
        end
        rd_en = 1'b0;
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 32; i++)
            for (int p = 0; p < 2; p++)
                chk(5'(i), p[0], tag);
    endtask

    task automatic wr(input logic [4:0] s, input bit p, input logic [31:0] v, input string tag);
        @(negedge clk);
        sel = s; priv = p; wdata = v; wr_en = 1'b1;
        #1;
        tests++;
        if (unk_err !== (p && is_unk(s))) begin
            fails++;
            $display("FAIL R10 (%s) write err sel=%0d actual=%b expected=%b", tag, s, unk_err, p && is_unk(s));
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (s < 5'd8) m_flags = v[31:27];
        else if (p) begin
            case (s)
                5'd8:  m_msp = v;
                5'd9:  m_psp = v;
                5'd16: m_pm  = v[0];
                5'd17: m_bp  = v[7:0];
                5'd19: m_fm  = v[0];
                5'd20: m_ctrl = v[1:0];
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sweep("R1");

        // Status views and flag writes
        exc_num = 9'h1FF;
        wr(5'd0, 1'b0, 32'hFFFF_FFFF, "R4");
        sweep("R2");
        exc_num = 9'h0A5;
        wr(5'd5, 1'b1, 32'h2800_0000, "R4");
        sweep("R3");
        wr(5'd3, 1'b1, 32'h9000_0FFF, "R4");
        sweep("R2");

        // Stack pointers around stack-select changes
        wr(5'd8, 1'b1, 32'h1111_2222, "R5");
        wr(5'd9, 1'b1, 32'h3333_4444, "R5");
        sweep("R5");
        wr(5'd20, 1'b1, 32'hFFFF_FFFE, "R6");
        sweep("R6");
        wr(5'd8, 1'b1, 32'hAAAA_5555, "R5");
        wr(5'd9, 1'b1, 32'h0F0F_F0F0, "R5");
        sweep("R5");
        wr(5'd20, 1'b1, 32'h0000_0001, "R6");
        sweep("R6");

        // Mask registers
        wr(5'd16, 1'b1, 32'hFFFF_FFFF, "R7");
        wr(5'd17, 1'b1, 32'hFFFF_FFFF, "R7");
        wr(5'd19, 1'b1, 32'h0000_0003, "R7");
        sweep("R7");
        wr(5'd16, 1'b1, 32'hFFFF_FFFE, "R7");
        wr(5'd17, 1'b1, 32'h0000_015A, "R7");
        sweep("R7");

        // Unprivileged writes above 7 (R9), then unprivileged reads (R8)
        for (int i = 8; i < 32; i++) wr(5'(i), 1'b0, 32'h5A5A_5A5A, "R9");
        sweep("R8,R9");

        // Privileged writes to unimplemented numbers
        for (int i = 10; i < 32; i++)
            if (is_unk(5'(i))) wr(5'(i), 1'b1, 32'hFFFF_FFFF, "R10");
        sweep("R10");

        // R11: old value visible before the edge, new value after it
        @(negedge clk);
        sel = 5'd0; priv = 1'b1; wdata = 32'h5000_0000; wr_en = 1'b1; rd_en = 1'b1;
        #1;
        tests++;
        if (rdata !== exp_rd(5'd0, 1'b1)) begin
            fails++;
            $display("FAIL R11 before edge actual=%h expected=%h", rdata, exp_rd(5'd0, 1'b1));
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        m_flags = 5'b01010;
        tests++;
        if (rdata !== 32'h5000_0000) begin
            fails++;
            $display("FAIL R11 after edge actual=%h expected=%h", rdata, 32'h5000_0000);
        end
        rd_en = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule